// File: doc/BRIEF.md
# Hibernation Power-State Controller

This block moves a power-management device between normal operation and a low-power hibernation state. Software first arms a one-shot unlock by writing a key, then writes the hibernation control register. The written value carries a keep mask with one bit per regulator. On entry every regulator enable not covered by the keep mask is dropped. The always-on core supply enable stays high. The system reset output is held active and the power-good output is held inactive.

Any interrupt flag whose enable bit is set ends hibernation. Wake-up replays the start-up sequence picked by a configuration strap. The strap is captured only once, on the first clock after a cold reset, and is never sampled again. The sequence turns regulators on one per step, with a programmable gap between steps. Reset is released and power-good is asserted when the last step runs. A cold reset runs the same sequence. A state output exposes the controller's phase.

Top module: `hib_ctrl`

## Requirements
- R1: A write to the control register (address 0x0B) has no effect unless the unlock is armed. The unlock is armed only by writing the value 0x06 to the key register (address 0x0A).
- R2: Conditions: the unlock is armed, the state is RUN, and no enabled flag is pending. Then a control write moves the state to ENTER on the next cycle and to HIB on the cycle after. Write data bits [N_REG-1:0] form the keep mask.
- R3: In HIB, core_en_o stays 1. reg_en_o equals the enables held before entry ANDed with the keep mask.
- R4: sys_rst_o is 1 and pwr_ok_o is 0 from the cycle HIB is reached until the last wake step.
- R5: Only flags whose bit is set in the interrupt enable register (address 0x0C, bits [N_IRQ-1:0]) end hibernation. An enabled active flag in HIB moves the state to WAKE on the next cycle.
- R6: If an enabled flag is pending when an armed control write arrives, entry is refused and the state stays RUN.
- R7: strap_i is captured on the first clock after a cold reset. A wake reuses the captured value even if the pin has changed.
- R8: A regulator outside the captured sequence is never enabled, whatever its keep bit says.
- R9: Sequence s powers regulators 0..N_REG-1-s. The order is ascending for even s and descending for odd s. With gap D (register 0x0D, reset value 2), step k enables its regulator (k+1)*(D+1) cycles after the WAKE entry edge. The last step also returns the state to RUN, sets sys_rst_o to 0 and sets pwr_ok_o to 1.
- R10: The unlock is single-use. Any control write clears it, and so does a key write of any value other than 0x06.
- R11: state_o encodes RUN=0, ENTER=1, HIB=2, WAKE=3. During reset the state is WAKE, reg_en_o is 0, sys_rst_o is 1 and pwr_ok_o is 0. A cold start runs the sequence counted from the first clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Cold power-on reset, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| irq_flag_i | input | N_IRQ | Pending interrupt flags |
| strap_i | input | SEQ_W | Start-up sequence select strap |
| core_en_o | output | 1 | Always-on core supply enable |
| reg_en_o | output | N_REG | Per-regulator enables |
| sys_rst_o | output | 1 | System reset, active high |
| pwr_ok_o | output | 1 | Power good |
| state_o | output | 2 | Controller phase |

## Verification
A write captured at edge E shows ENTER after E and HIB with masked enables after E+1. An enabled flag seen at edge H shows WAKE after H. Wake step k lands at H+(k+1)*(D+1), and the last step also flips the reset and power-good outputs. Cold-start steps are counted the same way, from the first edge after reset. The bench computes each of these absolute cycle numbers before it drives the stimulus and queues the expected outputs with them. A monitor compares each queued item at the falling edge of its cycle, and reports any item whose cycle has already passed as a failure.

// File: rtl/hib_pkg.sv
package hib_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_HIB   = 2'd2,
    ST_WAKE  = 2'd3
  } hib_state_e;

  localparam logic [7:0] KEY_VAL    = 8'h06;
  localparam logic [7:0] ADDR_KEY   = 8'h0A;
  localparam logic [7:0] ADDR_CTL   = 8'h0B;
  localparam logic [7:0] ADDR_IRQEN = 8'h0C;
  localparam logic [7:0] ADDR_DLY   = 8'h0D;
endpackage

// File: rtl/hib_regs.sv
module hib_regs
  import hib_pkg::*;
#(
  parameter int N_REG = 6,
  parameter int N_IRQ = 8,
  parameter int DLY_W = 8,
  parameter logic [DLY_W-1:0] DLY_RST = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  output logic             ctl_wr_o,
  output logic [N_REG-1:0] ctl_data_o,
  output logic             unlock_o,
  output logic [N_IRQ-1:0] irq_en_o,
  output logic [DLY_W-1:0] step_dly_o
);
  logic             unlock_q;
  logic [N_IRQ-1:0] irq_en_q;
  logic [DLY_W-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q <= 1'b0;
      irq_en_q <= '0;
      dly_q    <= DLY_RST;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_KEY:   unlock_q <= (wr_data_i == KEY_VAL);
        ADDR_CTL:   unlock_q <= 1'b0;   // single-use
        ADDR_IRQEN: irq_en_q <= wr_data_i[N_IRQ-1:0];
        ADDR_DLY:   dly_q    <= wr_data_i[DLY_W-1:0];
        default: ;
      endcase
    end
  end

  assign ctl_wr_o   = wr_en_i && (wr_addr_i == ADDR_CTL) && unlock_q;
  assign ctl_data_o = wr_data_i[N_REG-1:0];
  assign unlock_o   = unlock_q;
  assign irq_en_o   = irq_en_q;
  assign step_dly_o = dly_q;
endmodule

// File: rtl/hib_seq.sv
module hib_seq #(
  parameter int N_REG = 6,
  parameter int SEQ_W = 2,
  localparam int IDX_W = $clog2(N_REG),
  localparam int CNT_W = $clog2(N_REG + 1)
) (
  input  logic [SEQ_W-1:0] sel_i,
  input  logic [CNT_W-1:0] step_i,
  output logic [IDX_W-1:0] reg_idx_o,
  output logic [N_REG-1:0] used_mask_o,
  output logic [CNT_W-1:0] n_steps_o
);
  int len;
  int idx;

  // sequence s: regulators 0..N_REG-1-s, odd s runs top-down
  always_comb begin
    len = (int'(sel_i) < N_REG) ? N_REG - int'(sel_i) : 1;
    idx = sel_i[0] ? (len - 1 - int'(step_i)) : int'(step_i);
    reg_idx_o = IDX_W'(idx);
    n_steps_o = CNT_W'(len);
  end

  for (genvar g = 0; g < N_REG; g++) begin : g_used
    assign used_mask_o[g] = (g < len);
  end
endmodule

// File: rtl/hib_fsm.sv
module hib_fsm
  import hib_pkg::*;
#(
  parameter int N_REG = 6,
  parameter int SEQ_W = 2,
  parameter int DLY_W = 8,
  localparam int IDX_W = $clog2(N_REG),
  localparam int CNT_W = $clog2(N_REG + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEQ_W-1:0] strap_i,
  input  logic             ctl_wr_i,
  input  logic [N_REG-1:0] ctl_data_i,
  input  logic             irq_hit_i,
  input  logic [DLY_W-1:0] step_dly_i,
  input  logic [IDX_W-1:0] reg_idx_i,
  input  logic [N_REG-1:0] used_mask_i,
  input  logic [CNT_W-1:0] n_steps_i,
  output logic [SEQ_W-1:0] seq_sel_o,
  output logic [CNT_W-1:0] step_o,
  output logic [N_REG-1:0] keep_o,
  output logic [N_REG-1:0] reg_en_o,
  output logic             sys_rst_o,
  output logic             pwr_ok_o,
  output hib_state_e       state_o
);
  hib_state_e       state_q;
  logic [SEQ_W-1:0] seq_q;
  logic             strap_vld_q;
  logic [N_REG-1:0] keep_q, en_q;
  logic [CNT_W-1:0] step_q;
  logic [DLY_W-1:0] cnt_q;
  logic             rst_q, ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_WAKE;
      seq_q       <= '0;
      strap_vld_q <= 1'b0;
      keep_q      <= '0;
      en_q        <= '0;
      step_q      <= '0;
      cnt_q       <= '0;
      rst_q       <= 1'b1;
      ok_q        <= 1'b0;
    end else begin
      if (!strap_vld_q) begin
        seq_q       <= strap_i;   // captured once per cold reset
        strap_vld_q <= 1'b1;
      end
      unique case (state_q)
        ST_RUN: begin
          if (ctl_wr_i && !irq_hit_i) begin
            state_q <= ST_ENTER;
            keep_q  <= ctl_data_i & used_mask_i;
          end
        end
        ST_ENTER: begin
          state_q <= ST_HIB;
          en_q    <= en_q & keep_q;
          rst_q   <= 1'b1;
          ok_q    <= 1'b0;
        end
        ST_HIB: begin
          if (irq_hit_i) begin
            state_q <= ST_WAKE;
            step_q  <= '0;
            cnt_q   <= '0;
          end
        end
        ST_WAKE: begin
          if (strap_vld_q) begin
            if (cnt_q == step_dly_i) begin
              cnt_q            <= '0;
              en_q[reg_idx_i]  <= 1'b1;
              step_q           <= step_q + 1'b1;
              if (step_q == CNT_W'(n_steps_i - 1'b1)) begin
                state_q <= ST_RUN;
                rst_q   <= 1'b0;
                ok_q    <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign seq_sel_o = seq_q;
  assign step_o    = step_q;
  assign keep_o    = keep_q;
  assign reg_en_o  = en_q;
  assign sys_rst_o = rst_q;
  assign pwr_ok_o  = ok_q;
  assign state_o   = state_q;
endmodule

// File: rtl/hib_ctrl.sv
module hib_ctrl
  import hib_pkg::*;
#(
  parameter int N_REG = 6,
  parameter int N_IRQ = 8,
  parameter int SEQ_W = 2,
  parameter int DLY_W = 8,
  parameter logic [DLY_W-1:0] DLY_RST = 2,
  localparam int IDX_W = $clog2(N_REG),
  localparam int CNT_W = $clog2(N_REG + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic [N_IRQ-1:0] irq_flag_i,
  input  logic [SEQ_W-1:0] strap_i,
  output logic             core_en_o,
  output logic [N_REG-1:0] reg_en_o,
  output logic             sys_rst_o,
  output logic             pwr_ok_o,
  output logic [1:0]       state_o
);
  logic             ctl_wr;
  logic [N_REG-1:0] ctl_data;
  logic             unlock_w;
  logic [N_IRQ-1:0] irq_en;
  logic [DLY_W-1:0] step_dly;
  logic             irq_hit;
  logic [SEQ_W-1:0] seq_sel;
  logic [CNT_W-1:0] step;
  logic [IDX_W-1:0] reg_idx;
  logic [N_REG-1:0] used_mask;
  logic [CNT_W-1:0] n_steps;
  logic [N_REG-1:0] keep_w;
  hib_state_e       state;

  hib_regs #(.N_REG(N_REG), .N_IRQ(N_IRQ), .DLY_W(DLY_W), .DLY_RST(DLY_RST)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctl_wr_o(ctl_wr), .ctl_data_o(ctl_data), .unlock_o(unlock_w),
    .irq_en_o(irq_en), .step_dly_o(step_dly)
  );

  assign irq_hit = |(irq_flag_i & irq_en);

  hib_seq #(.N_REG(N_REG), .SEQ_W(SEQ_W)) u_seq (
    .sel_i(seq_sel), .step_i(step), .reg_idx_o(reg_idx),
    .used_mask_o(used_mask), .n_steps_o(n_steps)
  );

  hib_fsm #(.N_REG(N_REG), .SEQ_W(SEQ_W), .DLY_W(DLY_W)) u_fsm (
    .clk_i, .rst_ni, .strap_i,
    .ctl_wr_i(ctl_wr), .ctl_data_i(ctl_data), .irq_hit_i(irq_hit),
    .step_dly_i(step_dly), .reg_idx_i(reg_idx), .used_mask_i(used_mask),
    .n_steps_i(n_steps), .seq_sel_o(seq_sel), .step_o(step), .keep_o(keep_w),
    .reg_en_o(reg_en_o), .sys_rst_o(sys_rst_o), .pwr_ok_o(pwr_ok_o), .state_o(state)
  );

  assign core_en_o = 1'b1;   // always-on rail
  assign state_o   = state;
endmodule

// File: rtl/hib_ctrl_chk.sv
module hib_ctrl_chk
  import hib_pkg::*;
#(
  parameter int N_REG = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       state_i,
  input logic [N_REG-1:0] reg_en_i,
  input logic [N_REG-1:0] keep_i,
  input logic             sys_rst_i,
  input logic             pwr_ok_i,
  input logic             irq_hit_i,
  input logic             ctl_wr_i,
  input logic             wr_en_i,
  input logic [7:0]       wr_addr_i,
  input logic             unlock_i
);
  a_r1_no_entry_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && !ctl_wr_i) |=> (state_i != ST_ENTER));

  a_r2_enter_then_hib: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ENTER) |=> (state_i == ST_HIB));

  a_r3_keep_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_HIB) |-> ((reg_en_i & ~keep_i) == '0));

  a_r4_hib_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_HIB) |-> (sys_rst_i && !pwr_ok_i));

  a_r5_stay_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_HIB && !irq_hit_i) |=> (state_i == ST_HIB));

  a_r6_refuse_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && irq_hit_i) |=> (state_i == ST_RUN));

  a_r9_one_per_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAKE) |=>
      ($countones(reg_en_i) <= $countones($past(reg_en_i)) + 1) &&
      (($past(reg_en_i) & ~reg_en_i) == '0));

  a_r10_unlock_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_CTL) |=> !unlock_i);
endmodule

bind hib_ctrl hib_ctrl_chk #(.N_REG(N_REG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state_o), .reg_en_i(reg_en_o),
  .keep_i(keep_w), .sys_rst_i(sys_rst_o), .pwr_ok_i(pwr_ok_o),
  .irq_hit_i(irq_hit), .ctl_wr_i(ctl_wr), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .unlock_i(unlock_w)
);

// File: tb/hib_ctrl_tb_top.sv
`timescale 1ns/1ps
module hib_ctrl_tb_top;
  localparam int N_REG = 6;
  localparam int N_IRQ = 8;
  localparam logic [7:0] A_KEY = 8'h0A, A_CTL = 8'h0B, A_IEN = 8'h0C, A_DLY = 8'h0D;
  localparam logic [1:0] S_RUN = 2'd0, S_ENT = 2'd1, S_HIB = 2'd2, S_WAK = 2'd3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [7:0]       wr_addr = '0;
  logic [7:0]       wr_data = '0;
  logic [N_IRQ-1:0] irq_flag = '0;
  logic [1:0]       strap = 2'd1;
  logic             core_en;
  logic [N_REG-1:0] reg_en;
  logic             sys_rst, pwr_ok;
  logic [1:0]       state;

  always #2.5 clk = ~clk;

  hib_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .irq_flag_i(irq_flag), .strap_i(strap),
    .core_en_o(core_en), .reg_en_o(reg_en), .sys_rst_o(sys_rst),
    .pwr_ok_o(pwr_ok), .state_o(state)
  );

  int cyc;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  typedef struct {
    int               at;
    logic [N_REG-1:0] en;
    logic             sr;
    logic             pk;
    logic [1:0]       st;
    string            tag;
  } exp_t;
  exp_t q[$];

  int  n_run = 0, n_fail = 0;
  bit  done = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s cyc=%0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic exp_at(int at, logic [N_REG-1:0] en, logic sr, logic pk,
                        logic [1:0] st, string tag);
    exp_t e;
    e.at = at; e.en = en; e.sr = sr; e.pk = pk; e.st = st; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares queued items at the falling edge of their cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.at < cyc) begin
        n_run++; n_fail++;
        $display("FAIL %s missed item: actual cyc %0d expected cyc %0d", e.tag, cyc, e.at);
      end else begin
        chk(e.tag, 32'({reg_en, sys_rst, pwr_ok, state}),
            32'({e.en, e.sr, e.pk, e.st}), "{en,rst,ok,st}");
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : drv
    int e0, h;
    repeat (3) @(negedge clk);
    // R11 reset state, R3 core rail
    chk("R11", 32'({reg_en, sys_rst, pwr_ok, state}), 32'({6'h00, 1'b1, 1'b0, S_WAK}), "reset");
    chk("R3", 32'(core_en), 32'd1, "core_en in reset");

    // R11/R9 cold start with strap 1: regs 4,3,2,1,0, D=2, steps at 1+3(k+1)
    exp_at(3,  6'h00, 1, 0, S_WAK, "R11");
    exp_at(4,  6'h10, 1, 0, S_WAK, "R9");
    exp_at(7,  6'h18, 1, 0, S_WAK, "R9");
    exp_at(10, 6'h1C, 1, 0, S_WAK, "R9");
    exp_at(15, 6'h1E, 1, 0, S_WAK, "R4");
    exp_at(16, 6'h1F, 0, 1, S_RUN, "R9");
    rst_n = 1'b1;
    @(negedge clk);
    strap = 2'd3;   // R7: pin change after capture must be ignored
    drain();

    // R1: control write without unlock
    e0 = cyc + 1;
    exp_at(e0, 6'h1F, 0, 1, S_RUN, "R1");
    exp_at(e0 + 1, 6'h1F, 0, 1, S_RUN, "R1");
    wr(A_CTL, 8'h00);
    drain();

    // R1: wrong key
    wr(A_KEY, 8'h05);
    e0 = cyc + 1;
    exp_at(e0 + 1, 6'h1F, 0, 1, S_RUN, "R1");
    wr(A_CTL, 8'h00);
    drain();

    // R10: valid key then other value disarms
    wr(A_KEY, 8'h06);
    wr(A_KEY, 8'h07);
    e0 = cyc + 1;
    exp_at(e0 + 1, 6'h1F, 0, 1, S_RUN, "R10");
    wr(A_CTL, 8'h00);
    drain();

    // R6: enabled flag pending at entry -> refused
    wr(A_IEN, 8'h01);
    irq_flag = 8'h01;
    wr(A_KEY, 8'h06);
    e0 = cyc + 1;
    exp_at(e0, 6'h1F, 0, 1, S_RUN, "R6");
    exp_at(e0 + 1, 6'h1F, 0, 1, S_RUN, "R6");
    wr(A_CTL, 8'h3F);
    irq_flag = 8'h00;
    // R10: unlock consumed by the refused write
    e0 = cyc + 1;
    exp_at(e0 + 1, 6'h1F, 0, 1, S_RUN, "R10");
    wr(A_CTL, 8'h00);
    drain();

    // R2/R3/R4/R8: keep bits 0,1,5; reg5 outside sequence 1
    wr(A_KEY, 8'h06);
    e0 = cyc + 1;
    exp_at(e0, 6'h1F, 0, 1, S_ENT, "R2");
    exp_at(e0 + 1, 6'h03, 1, 0, S_HIB, "R3");
    exp_at(e0 + 4, 6'h03, 1, 0, S_HIB, "R5");
    exp_at(e0 + 5, 6'h03, 1, 0, S_HIB, "R8");
    wr(A_CTL, 8'h23);
    @(negedge clk);
    irq_flag = 8'h02;   // R5: not enabled
    repeat (4) @(negedge clk);
    chk("R3", 32'(core_en), 32'd1, "core_en in hibernation");

    // R5/R7/R9: wake, sequence 1 reused though strap is 3
    h = cyc + 1;
    exp_at(h,      6'h03, 1, 0, S_WAK, "R5");
    exp_at(h + 2,  6'h03, 1, 0, S_WAK, "R9");
    exp_at(h + 3,  6'h13, 1, 0, S_WAK, "R7");
    exp_at(h + 6,  6'h1B, 1, 0, S_WAK, "R9");
    exp_at(h + 9,  6'h1F, 1, 0, S_WAK, "R9");
    exp_at(h + 14, 6'h1F, 1, 0, S_WAK, "R4");
    exp_at(h + 15, 6'h1F, 0, 1, S_RUN, "R8");
    irq_flag = 8'h03;
    @(negedge clk);
    irq_flag = 8'h00;
    drain();

    // R9: gap 0, keep nothing
    wr(A_DLY, 8'h00);
    wr(A_KEY, 8'h06);
    e0 = cyc + 1;
    exp_at(e0, 6'h1F, 0, 1, S_ENT, "R2");
    exp_at(e0 + 1, 6'h00, 1, 0, S_HIB, "R3");
    wr(A_CTL, 8'h00);
    repeat (2) @(negedge clk);
    h = cyc + 1;
    exp_at(h,     6'h00, 1, 0, S_WAK, "R5");
    exp_at(h + 1, 6'h10, 1, 0, S_WAK, "R9");
    exp_at(h + 2, 6'h18, 1, 0, S_WAK, "R9");
    exp_at(h + 3, 6'h1C, 1, 0, S_WAK, "R9");
    exp_at(h + 4, 6'h1E, 1, 0, S_WAK, "R9");
    exp_at(h + 5, 6'h1F, 0, 1, S_RUN, "R9");
    irq_flag = 8'h01;
    @(negedge clk);
    irq_flag = 8'h00;
    drain();

    // R10: unlock not re-armed after a completed entry
    e0 = cyc + 1;
    exp_at(e0 + 1, 6'h1F, 0, 1, S_RUN, "R10");
    wr(A_CTL, 8'h00);
    drain();

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule